// File: doc/BRIEF.md
# Vector Narrowing Add/Subtract High-Half Unit

This block is a SIMD datapath that takes two 128-bit vectors of wide lanes and adds or subtracts them lane by lane. From each wide result it keeps only the upper half, which gives a narrowed lane. The two 64-bit doublewords of each source are processed independently. Their narrowed halves are packed into one 64-bit result, with the low doubleword's lanes in the low 32 bits.

A rounding select adds half the weight of the kept least significant bit to each wide lane before truncation, so the narrowed value is rounded to nearest. A legality stage checks the operation against the size code and the register-index fields. An illegal request raises an undefined-operation flag in place of a result. The result, the result-valid strobe and the undefined flag are all registered one cycle after the request strobe.

Top module: `vnarrow_hn`

## Requirements
- R1: With size code 0, each 16-bit lane i (operand bits [16i+15:16i]) produces the upper byte of the modular 16-bit sum. The byte is placed at bits [8i+7:8i] of its doubleword's 32-bit slot.
- R2: With size code 1, each 32-bit lane i yields the upper 16 bits of the modular 32-bit sum at slot bits [16i+15:16i].
- R3: With size code 2, each 64-bit lane yields the upper 32 bits of the modular 64-bit sum.
- R4: When sub_sel is 1, the lane operation is opa minus opb, taken modulo the wide lane width.
- R5: When rnd_sel is 1, a bias of 1 << (L/2-1) is added to each wide lane of width L before truncation. Any overflow out of the wide lane is discarded.
- R6: Doubleword opa/opb[63:0] produces res_data[31:0], and doubleword [127:64] produces res_data[63:32].
- R7: Size code 3 raises undef_flag.
- R8: An odd idx_n or an odd idx_m raises undef_flag. An odd idx_d is legal.
- R9: When ext_bank_en is 0, bit 4 set in any of idx_d, idx_n or idx_m raises undef_flag. When ext_bank_en is 1, that bit is legal.
- R10: res_valid pulses for exactly one cycle, in the cycle after an accepted in_valid. With no in_valid, neither output strobe rises.
- R11: In the cycle undef_flag is raised, res_valid is 0 and res_data keeps its previous value.
- R12: After reset, res_valid, undef_flag and res_data are all 0.
- R13: Carries and borrows never cross lane boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opa | input | 128 | First wide-lane operand |
| opb | input | 128 | Second wide-lane operand |
| size_sel | input | 2 | Lane size code (0: 16 to 8, 1: 32 to 16, 2: 64 to 32, 3: illegal) |
| sub_sel | input | 1 | 1 selects subtraction, 0 selects addition |
| rnd_sel | input | 1 | 1 selects the rounding variant |
| idx_d | input | 5 | Destination register index (legality only) |
| idx_n | input | 5 | First source register index (legality only) |
| idx_m | input | 5 | Second source register index (legality only) |
| ext_bank_en | input | 1 | 1 when indices with bit 4 set are allowed |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Packed narrowed result |
| undef_flag | output | 1 | Illegal-request flag |

## Verification
The hardest situation to reach is a carry or rounding bias that crosses the half-lane boundary, or overflows the wide lane, without spilling into the neighbouring lane. Random operands seldom land on these values. The stimulus table therefore uses all-ones lanes, lanes sitting just below the half boundary, and lanes whose lower half is exactly the rounding threshold, and runs each of them under every size code. Undefined requests follow a valid result, so the bench can see that the held result survives.

// File: rtl/vnh_pkg.sv
package vnh_pkg;

    typedef enum logic [1:0] {
        SZ_16_TO_8  = 2'd0,
        SZ_32_TO_16 = 2'd1,
        SZ_64_TO_32 = 2'd2,
        SZ_ILLEGAL  = 2'd3
    } lane_size_e;

    localparam int MIN_LANE_W = 16;

endpackage

// File: rtl/vnh_dword.sv
module vnh_dword
    import vnh_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [1:0]      size_i,
    input  logic            sub_i,
    input  logic            rnd_i,
    output logic [DW/2-1:0] hi_o
);
    localparam int NSZ = $clog2(DW / MIN_LANE_W) + 1;

    logic [DW/2-1:0] per_sz [NSZ];

    for (genvar s = 0; s < NSZ; s++) begin : g_sz
        localparam int LW = MIN_LANE_W << s;
        localparam int HW = LW / 2;
        localparam int NL = DW / LW;
        logic [DW/2-1:0] nar;
        for (genvar l = 0; l < NL; l++) begin : g_ln
            logic [LW-1:0] av_d;
            logic [LW-1:0] bv_d;
            logic [LW-1:0] bias_d;
            logic [LW-1:0] wide_d;
            always_comb begin
                av_d   = a_i[l*LW +: LW];
                bv_d   = b_i[l*LW +: LW];
                bias_d = rnd_i ? (LW'(1) << (HW - 1)) : '0;
                wide_d = (sub_i ? (av_d - bv_d) : (av_d + bv_d)) + bias_d;
            end
            assign nar[l*HW +: HW] = HW'(wide_d >> HW);
        end
        assign per_sz[s] = nar;
    end

    always_comb begin
        hi_o = '0;
        for (int s = 0; s < NSZ; s++) begin
            if (int'(size_i) == s) begin
                hi_o = per_sz[s];
            end
        end
    end

endmodule

// File: rtl/vnh_legal.sv
module vnh_legal
    import vnh_pkg::*;
#(
    parameter int RIW = 5
) (
    input  logic [1:0]     size_i,
    input  logic [RIW-1:0] idx_d_i,
    input  logic [RIW-1:0] idx_n_i,
    input  logic [RIW-1:0] idx_m_i,
    input  logic           ext_en_i,
    output logic           illegal_o
);
    logic bad_size_d;
    logic odd_src_d;
    logic bank_d;

    always_comb begin
        bad_size_d = (lane_size_e'(size_i) == SZ_ILLEGAL);
        odd_src_d  = idx_n_i[0] | idx_m_i[0];
        bank_d     = !ext_en_i && (|((idx_d_i | idx_n_i | idx_m_i) >> (RIW - 1)));
        illegal_o  = bad_size_d | odd_src_d | bank_d;
    end

endmodule

// File: rtl/vnarrow_hn.sv
module vnarrow_hn
    import vnh_pkg::*;
#(
    parameter int DW    = 64,
    parameter int NDW   = 2,
    parameter int RIW   = 5,
    localparam int OPW  = DW * NDW,
    localparam int RESW = (DW / 2) * NDW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OPW-1:0]  opa,
    input  logic [OPW-1:0]  opb,
    input  logic [1:0]      size_sel,
    input  logic            sub_sel,
    input  logic            rnd_sel,
    input  logic [RIW-1:0]  idx_d,
    input  logic [RIW-1:0]  idx_n,
    input  logic [RIW-1:0]  idx_m,
    input  logic            ext_bank_en,
    output logic            res_valid,
    output logic [RESW-1:0] res_data,
    output logic            undef_flag
);
    typedef struct packed {
        logic            vld;
        logic            und;
        logic [RESW-1:0] data;
    } out_state_t;

    out_state_t      st_d;
    out_state_t      st_q;
    logic [RESW-1:0] packed_d;
    logic            illegal_d;

    for (genvar h = 0; h < NDW; h++) begin : g_dw
        vnh_dword #(.DW(DW)) u_dword (
            .a_i    (opa[h*DW +: DW]),
            .b_i    (opb[h*DW +: DW]),
            .size_i (size_sel),
            .sub_i  (sub_sel),
            .rnd_i  (rnd_sel),
            .hi_o   (packed_d[h*(DW/2) +: DW/2])
        );
    end

    vnh_legal #(.RIW(RIW)) u_legal (
        .size_i    (size_sel),
        .idx_d_i   (idx_d),
        .idx_n_i   (idx_n),
        .idx_m_i   (idx_m),
        .ext_en_i  (ext_bank_en),
        .illegal_o (illegal_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.und = 1'b0;
        if (in_valid) begin
            if (illegal_d) begin
                st_d.und = 1'b1;
            end else begin
                st_d.vld  = 1'b1;
                st_d.data = packed_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.vld;
    assign undef_flag = st_q.und;
    assign res_data   = st_q.data;

endmodule

// File: rtl/vnh_checker.sv
module vnh_checker #(
    parameter int OPW  = 128,
    parameter int RESW = 64,
    parameter int RIW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OPW-1:0]  opa,
    input logic [OPW-1:0]  opb,
    input logic [1:0]      size_sel,
    input logic            sub_sel,
    input logic            rnd_sel,
    input logic [RIW-1:0]  idx_d,
    input logic [RIW-1:0]  idx_n,
    input logic [RIW-1:0]  idx_m,
    input logic            ext_bank_en,
    input logic            res_valid,
    input logic [RESW-1:0] res_data,
    input logic            undef_flag
);
    p_strobes_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && undef_flag));

    p_undef_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> $stable(res_data));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !undef_flag));

    p_req_answers_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_valid || undef_flag));

    p_size3_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel == 2'd3) |=> undef_flag);

    p_odd_src_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (idx_n[0] || idx_m[0])) |=> undef_flag);

    p_bank_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ext_bank_en && (idx_d[RIW-1] || idx_n[RIW-1] || idx_m[RIW-1])) |=> undef_flag);

    p_reset_state_r12: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !undef_flag));

endmodule

bind vnarrow_hn vnh_checker #(.OPW(OPW), .RESW(RESW), .RIW(RIW)) u_chk (.*);

// File: tb/vnarrow_hn_tb.sv
`timescale 1ns/1ps
module vnarrow_hn_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [1:0]   size_sel = '0;
    logic         sub_sel = 1'b0;
    logic         rnd_sel = 1'b0;
    logic [4:0]   idx_d = '0;
    logic [4:0]   idx_n = '0;
    logic [4:0]   idx_m = '0;
    logic         ext_bank_en = 1'b1;
    logic         res_valid;
    logic [63:0]  res_data;
    logic         undef_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vnarrow_hn u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .size_sel(size_sel), .sub_sel(sub_sel), .rnd_sel(rnd_sel),
        .idx_d(idx_d), .idx_n(idx_n), .idx_m(idx_m), .ext_bank_en(ext_bank_en),
        .res_valid(res_valid), .res_data(res_data), .undef_flag(undef_flag)
    );

    typedef struct packed {
        logic [127:0] a;
        logic [127:0] b;
        logic [1:0]   sz;
        logic         sub;
        logic         rnd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        {128'h00FF_7FFF_8000_FFFF_0001_1234_FFFF_0080, 128'h0001_0001_8000_0001_FFFF_1234_FFFF_0080, 2'd0, 1'b0, 1'b0},
        {128'h00FF_7FFF_8000_FFFF_0001_1234_FFFF_0080, 128'h0001_0001_8000_0001_FFFF_1234_FFFF_0080, 2'd0, 1'b0, 1'b1},
        {128'h0000_0100_8000_FF7F_0080_007F_FFFF_1234, 128'h0001_0001_0001_0001_0000_0000_FFFF_4321, 2'd0, 1'b1, 1'b0},
        {128'h0000_0100_8000_FF7F_0080_007F_FFFF_1234, 128'h0001_0001_0001_0001_0000_0000_FFFF_4321, 2'd0, 1'b1, 1'b1},
        {128'hFFFF_FFFF_0000_FFFF_1234_5678_7FFF_8000, 128'h0000_0001_0000_0001_8765_4321_0000_8000, 2'd1, 1'b0, 1'b0},
        {128'hFFFF_FFFF_0000_FFFF_1234_5678_7FFF_8000, 128'h0000_0001_0000_0001_8765_4321_0000_8000, 2'd1, 1'b0, 1'b1},
        {128'h0000_0000_FFFF_0000_8000_0000_0000_7FFF, 128'h0000_0001_0000_0001_0000_0001_FFFF_FFFF, 2'd1, 1'b1, 1'b0},
        {128'h0000_0000_FFFF_0000_8000_0000_0000_7FFF, 128'h0000_0001_0000_0001_0000_0001_FFFF_FFFF, 2'd1, 1'b1, 1'b1},
        {128'hFFFF_FFFF_FFFF_FFFF_0000_0000_FFFF_FFFF, 128'h0000_0000_0000_0001_0000_0000_0000_0001, 2'd2, 1'b0, 1'b0},
        {128'hFFFF_FFFF_FFFF_FFFF_0000_0000_7FFF_FFFF, 128'h0000_0000_0000_0000_0000_0000_0000_0001, 2'd2, 1'b0, 1'b1},
        {128'h0000_0000_0000_0000_1234_5678_9ABC_DEF0, 128'h0000_0000_0000_0001_0FED_CBA9_8765_4321, 2'd2, 1'b1, 1'b0},
        {128'h0000_0000_0000_0000_1234_5678_9ABC_DEF0, 128'h0000_0000_0000_0001_0FED_CBA9_8765_4321, 2'd2, 1'b1, 1'b1},
        {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 1'b1},
        {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 1'b1}
    };

    function automatic logic [63:0] ref_res(logic [127:0] a, logic [127:0] b,
                                            logic [1:0] sz, logic sub, logic rnd);
        int lw = 16 << sz;
        int hw = lw / 2;
        logic [63:0] lm = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
        logic [63:0] hm = (64'd1 << hw) - 64'd1;
        logic [63:0] r = '0;
        for (int h = 0; h < 2; h++) begin
            for (int l = 0; l < 64 / lw; l++) begin
                logic [63:0] av = 64'(a >> (h * 64 + l * lw)) & lm;
                logic [63:0] bv = 64'(b >> (h * 64 + l * lw)) & lm;
                logic [64:0] t = sub ? ({1'b0, av} - {1'b0, bv}) : ({1'b0, av} + {1'b0, bv});
                if (rnd) t = t + (65'd1 << (hw - 1));
                r = r | (((64'(t >> hw)) & hm) << (h * 32 + l * hw));
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                         input logic sub, input logic rnd, input logic [4:0] d,
                         input logic [4:0] n, input logic [4:0] m, input logic ext);
        opa = a; opb = b; size_sel = sz; sub_sel = sub; rnd_sel = rnd;
        idx_d = d; idx_n = n; idx_m = m; ext_bank_en = ext; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [63:0] held;
        logic [127:0] ca;
        logic [127:0] cb;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 valid", 64'(res_valid), 64'd0);
        chk("R12 undef", 64'(undef_flag), 64'd0);
        chk("R12 data", res_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1-R5, R13 table walk (size 0 rows cover R1, size 1 R2, size 2 R3)
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].a, TBL[i].b, TBL[i].sz, TBL[i].sub, TBL[i].rnd, 5'd0, 5'd2, 5'd4, 1'b1);
            chk("R10 valid", 64'(res_valid), 64'd1);
            chk("R1 R2 R3 R4 R5 R13 data", res_data,
                ref_res(TBL[i].a, TBL[i].b, TBL[i].sz, TBL[i].sub, TBL[i].rnd));
        end

        // R6: doubleword placement, only the high doubleword nonzero
        ca = {64'h1111_2222_3333_4444, 64'd0};
        apply(ca, 128'd0, 2'd2, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1);
        chk("R6 packing", res_data, 64'h1111_2222_0000_0000);

        // R13: carry stops at lane edge (size 0, low lane overflows)
        ca = {112'd0, 16'hFFFF};
        cb = {112'd0, 16'h0001};
        apply(ca, cb, 2'd0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1);
        chk("R13 no cross carry", res_data, 64'd0);

        // R10: idle cycle produces no strobe
        @(negedge clk);
        chk("R10 idle valid", 64'(res_valid), 64'd0);
        chk("R10 idle undef", 64'(undef_flag), 64'd0);

        // R11 + R7: size 3 with held data
        held = res_data;
        apply(TBL[0].a, TBL[0].b, 2'd3, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1);
        chk("R7 undef", 64'(undef_flag), 64'd1);
        chk("R11 no valid", 64'(res_valid), 64'd0);
        chk("R11 hold", res_data, held);

        // R8: odd n, odd m, odd d
        apply(TBL[0].a, TBL[0].b, 2'd0, 1'b0, 1'b0, 5'd0, 5'd3, 5'd0, 1'b1);
        chk("R8 odd n", 64'(undef_flag), 64'd1);
        apply(TBL[0].a, TBL[0].b, 2'd0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd5, 1'b1);
        chk("R8 odd m", 64'(undef_flag), 64'd1);
        chk("R11 hold odd m", res_data, held);
        apply(TBL[0].a, TBL[0].b, 2'd0, 1'b0, 1'b0, 5'd7, 5'd0, 5'd0, 1'b1);
        chk("R8 odd d legal", 64'(res_valid), 64'd1);
        chk("R8 odd d data", res_data, ref_res(TBL[0].a, TBL[0].b, 2'd0, 1'b0, 1'b0));

        // R9: extended bank
        apply(TBL[4].a, TBL[4].b, 2'd1, 1'b0, 1'b0, 5'd0, 5'd16, 5'd0, 1'b0);
        chk("R9 bank off n", 64'(undef_flag), 64'd1);
        apply(TBL[4].a, TBL[4].b, 2'd1, 1'b0, 1'b0, 5'd17, 5'd0, 5'd0, 1'b0);
        chk("R9 bank off d", 64'(undef_flag), 64'd1);
        apply(TBL[4].a, TBL[4].b, 2'd1, 1'b0, 1'b0, 5'd17, 5'd16, 5'd18, 1'b1);
        chk("R9 bank on", 64'(res_valid), 64'd1);
        chk("R9 bank on data", res_data, ref_res(TBL[4].a, TBL[4].b, 2'd1, 1'b0, 1'b0));

        // R10: back-to-back requests
        opa = TBL[8].a; opb = TBL[8].b; size_sel = 2'd2; sub_sel = 1'b0; rnd_sel = 1'b0;
        idx_d = 0; idx_n = 0; idx_m = 0; ext_bank_en = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 b2b first", res_data, ref_res(TBL[8].a, TBL[8].b, 2'd2, 1'b0, 1'b0));
        opa = TBL[2].a; opb = TBL[2].b; size_sel = 2'd0; sub_sel = 1'b1; rnd_sel = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 b2b second", res_data, ref_res(TBL[2].a, TBL[2].b, 2'd0, 1'b1, 1'b1));
        @(negedge clk);
        chk("R10 single pulse", 64'(res_valid), 64'd0);

        report();
    end

endmodule